// File: doc/BRIEF.md
# EEPROM Page Write Buffer and Program Sequencer

This block sits behind the serial protocol engine of a two-wire EEPROM model. It holds the word address counter, a sixteen-byte page latch with a per-byte valid mask, and a behavioural byte array. During a write transaction the protocol engine hands over each received data byte. The byte is stored in the latch at the offset given by the low four address bits, and the counter then moves to the next location inside the same page. Nothing reaches the array until the engine reports the stop condition. At that point only the latch locations that actually received a byte are copied into the array.

After a commit the block holds `busy` high for a parameterised number of clock cycles, which stands in for the self-timed program cycle. While `busy` is high, every request from the engine is ignored. The engine uses this to withhold its acknowledge for acknowledge polling.

For reads, the engine steps the same counter, and the step carries across the whole address range. The byte at the counter is always visible on `rd_data`. A write-protect input blocks both the acceptance of data bytes and the program cycle.

Top module: `eeps_top`

## Requirements
- R1: After reset `cur_addr` is 0, `busy` is 0 and every array byte reads 8'hFF.
- R2: A pulse on `addr_load` while not busy sets `cur_addr` to `addr_value` on the next clock.
- R3: Each accepted data byte advances `cur_addr` by one in its low 4 bits only. The low 4 bits wrap from 15 to 0 and the upper bits are unchanged.
- R4: When more than 16 bytes arrive before a stop, a later byte replaces the earlier byte at the same page offset, and the array receives the latest value.
- R5: The array is unchanged until a stop. At the stop edge each page location that received a byte is written, at address {upper bits of `cur_addr`, offset}, and the other locations keep their contents.
- R6: A committing stop raises `busy` from the next cycle for exactly BUSY_CYCLES cycles.
- R7: While `busy` is high, `addr_load`, `wr_valid`, `rd_advance` and `stop_evt` have no effect on `cur_addr`, the array or the latch.
- R8: While `wp` is high, data bytes are not acknowledged or stored and do not move the counter. A stop with `wp` high starts no program cycle and leaves the array unchanged.
- R9: A stop with no data byte received since the previous stop leaves `busy` low.
- R10: A `rd_advance` pulse while not busy adds one to the full `cur_addr`, wrapping from the last array address to 0.
- R11: `rd_data` always shows the array byte at `cur_addr`.
- R12: `data_ack` is high in the same cycle as `wr_valid` exactly when neither `busy` nor `wp` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Load the word address counter |
| addr_value | input | ADDR_W | Address to load |
| wr_valid | input | 1 | A write data byte is offered |
| wr_data | input | 8 | Write data byte |
| data_ack | output | 1 | The offered byte is accepted |
| rd_advance | input | 1 | One read byte was transferred; step the counter |
| stop_evt | input | 1 | Stop condition seen on the bus |
| wp | input | 1 | Write protect |
| rd_data | output | 8 | Array byte at the current address |
| cur_addr | output | ADDR_W | Word address counter |
| busy | output | 1 | Program cycle in progress |

## Verification
The bench goes after the page wrap. A design that carried the write step into the upper address bits would scatter a long burst over two pages instead of overwriting the first bytes. It checks that partially filled pages keep their untouched neighbours; a design without a byte mask would write stale latch contents over them. The busy window is measured to the cycle and probed with every kind of request, since an off-by-one timer or a leaking request would corrupt the counter or the array. Protected writes, empty stops and the read wrap from the top address to zero are each checked, because a wrong design would start a spurious busy period or step into the wrong page.

// File: rtl/eeps_pkg.sv
// Shared constants and types for the page write sequencer.
// Assumes byte-wide storage and a power-of-two page size.
package eeps_pkg;
    localparam int BYTE_W     = 8;
    localparam int PAGE_BYTES = 16;
    localparam int OFS_W      = $clog2(PAGE_BYTES);
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/eeps_addr_ctr.sv
// Word address counter.
// A write step wraps inside the page; a read step wraps over the whole array.
// Assumes the caller has already gated the strobes by busy and write protect.
module eeps_addr_ctr
    import eeps_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              wr_step,
    input  logic              rd_step,
    output logic [ADDR_W-1:0] addr
);
    // Counter update, in priority order: load, page step, array step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_addr;
        else if (wr_step)
            addr <= {addr[ADDR_W-1:OFS_W], addr[OFS_W-1:0] + OFS_W'(1)};
        else if (rd_step)
            addr <= addr + ADDR_W'(1);
    end

    // R3: a write step never leaves the page
    p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !load) |=> addr[ADDR_W-1:OFS_W] == $past(addr[ADDR_W-1:OFS_W]));

    // R10: a read step from the top address wraps to zero
    p_top_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !load && !wr_step && addr == '1) |=> addr == '0);
endmodule

// File: rtl/eeps_page_buf.sv
// Page latch with a byte-valid mask.
// Stores each accepted byte at its page offset and marks that offset valid.
// Assumes clear and wr_en never occur in the same cycle.
module eeps_page_buf
    import eeps_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [OFS_W-1:0]                   offset,
    input  byte_t                              data,
    input  logic                               clear,
    output logic [PAGE_BYTES-1:0][BYTE_W-1:0]  latch,
    output logic [PAGE_BYTES-1:0]              mask
);
    // Byte storage; a repeated offset overwrites the older byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch <= '0;
        else if (wr_en)
            latch[offset] <= data;
    end

    // Valid mask; cleared when a stop closes the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (clear)
            mask <= '0;
        else if (wr_en)
            mask[offset] <= 1'b1;
    end

    // R4: the most recent byte at an offset is the one kept
    p_last_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> latch[$past(offset)] == $past(data));
endmodule

// File: rtl/eeps_prog_timer.sv
// Busy timer that models the self-timed program cycle.
// Assumes start is only raised while the timer is idle.
module eeps_prog_timer #(
    parameter int BUSY_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= CNT_W'(BUSY_CYCLES);
        else if (remain != '0)
            remain <= remain - CNT_W'(1);
    end

    // Busy whenever cycles remain.
    assign busy = (remain != '0);

    // R6: busy follows a start
    p_busy_rises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R6: busy ends after the last counted cycle
    p_busy_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (remain == CNT_W'(1) && !start) |=> !busy);

    // R7: no restart during a running cycle
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/eeps_array.sv
// Behavioural byte array with a masked page commit and an asynchronous read port.
// Assumes the array is small enough to be reset to the erased value.
module eeps_array
    import eeps_pkg::*;
#(
    parameter int    ADDR_W = 9,
    parameter byte_t ERASED = 8'hFF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic [ADDR_W-OFS_W-1:0]           page_idx,
    input  logic [PAGE_BYTES-1:0][BYTE_W-1:0] latch,
    input  logic [PAGE_BYTES-1:0]             mask,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output byte_t                             rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    // Erase on reset; on commit write only the valid page bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= ERASED;
        end else if (commit) begin
            for (int j = 0; j < PAGE_BYTES; j++)
                if (mask[j])
                    mem[{page_idx, OFS_W'(j)}] <= latch[j];
        end
    end

    // Read port.
    assign rd_data = mem[rd_addr];

    // R5: a valid offset-zero byte lands in its page
    p_commit_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mask[0]) |=> mem[{$past(page_idx), OFS_W'(0)}] == $past(latch[0]));
endmodule

// File: rtl/eeps_top.sv
// Page write buffer and program sequencer for a serial EEPROM model.
// Gates protocol-engine strobes by busy and write protect, steps the address
// counter, latches page bytes, commits them at stop and times the program cycle.
// Assumes the engine raises at most one of load, byte, read step or stop per cycle.
module eeps_top
    import eeps_pkg::*;
#(
    parameter int    ADDR_W      = 9,
    parameter int    BUSY_CYCLES = 1000,
    parameter byte_t ERASED      = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_value,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    output logic              data_ack,
    input  logic              rd_advance,
    input  logic              stop_evt,
    input  logic              wp,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              busy
);
    logic                              idle;
    logic                              load_g;
    logic                              rd_g;
    logic                              stop_g;
    logic                              commit;
    logic [PAGE_BYTES-1:0][BYTE_W-1:0] latch;
    logic [PAGE_BYTES-1:0]             mask;

    // Strobe gating: nothing is honoured during the program cycle.
    assign idle     = !busy;
    assign load_g   = addr_load && idle;
    assign data_ack = wr_valid && idle && !wp;
    assign rd_g     = rd_advance && idle;
    assign stop_g   = stop_evt && idle;
    assign commit   = stop_g && !wp && (mask != '0);

    eeps_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_g),
        .load_addr (addr_value),
        .wr_step   (data_ack),
        .rd_step   (rd_g),
        .addr      (cur_addr)
    );

    eeps_page_buf u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (data_ack),
        .offset (cur_addr[OFS_W-1:0]),
        .data   (wr_data),
        .clear  (stop_g),
        .latch  (latch),
        .mask   (mask)
    );

    eeps_array #(.ADDR_W(ADDR_W), .ERASED(ERASED)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .page_idx (cur_addr[ADDR_W-1:OFS_W]),
        .latch    (latch),
        .mask     (mask),
        .rd_addr  (cur_addr),
        .rd_data  (rd_data)
    );

    eeps_prog_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .busy  (busy)
    );

    // R7: the counter is frozen while busy
    p_busy_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cur_addr == $past(cur_addr));

    // R8: a protected stop starts no program cycle
    p_wp_no_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && wp && !busy) |=> !busy);

    // R9: an empty stop starts no program cycle
    p_empty_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !busy && mask == '0) |=> !busy);
endmodule

// File: tb/eeps_top_tb_top.sv
// Bench: behavioural reference model compared against the design every clock.
module eeps_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 9;
    localparam int DEPTH      = 1 << AW;
    localparam int NBUSY      = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_value = '0;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          data_ack;
    logic          rd_advance = 1'b0;
    logic          stop_evt = 1'b0;
    logic          wp = 1'b0;
    logic [7:0]    rd_data;
    logic [AW-1:0] cur_addr;
    logic          busy;

    eeps_top #(.ADDR_W(AW), .BUSY_CYCLES(NBUSY), .ERASED(8'hFF)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_load  (addr_load),
        .addr_value (addr_value),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .data_ack   (data_ack),
        .rd_advance (rd_advance),
        .stop_evt   (stop_evt),
        .wp         (wp),
        .rd_data    (rd_data),
        .cur_addr   (cur_addr),
        .busy       (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string req     = "R1";

    // Reference model state
    int m_mem [DEPTH];
    int m_latch [16];
    int m_mask;
    int m_addr;
    int m_cnt;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, compare, then advance the model at the edge.
    task automatic cyc(input bit ld, input int la, input bit wv, input int wd,
                       input bit rd, input bit st, input bit wpv);
        bit idle;
        bit ack;
        @(negedge clk);
        addr_load = ld; addr_value = AW'(la); wr_valid = wv; wr_data = 8'(wd);
        rd_advance = rd; stop_evt = st; wp = wpv;
        #1;
        idle = (m_cnt == 0);
        ack  = wv && idle && !wpv;
        chk({req, " cur_addr"}, int'(cur_addr), m_addr);
        chk({req, " busy"}, int'(busy), int'(m_cnt != 0));
        chk({"R11 rd_data in ", req}, int'(rd_data), m_mem[m_addr]);
        chk("R12 data_ack", int'(data_ack), int'(ack));
        @(posedge clk);
        if (!idle) m_cnt--;
        else begin
            if (ld) m_addr = la % DEPTH;
            else if (ack) begin
                m_latch[m_addr % 16] = wd & 255;
                m_mask |= (1 << (m_addr % 16));
                m_addr = (m_addr / 16) * 16 + ((m_addr + 1) % 16);
            end else if (rd) m_addr = (m_addr + 1) % DEPTH;
            if (st) begin
                if (m_mask != 0 && !wpv) begin
                    for (int i = 0; i < 16; i++)
                        if (m_mask[i]) m_mem[(m_addr / 16) * 16 + i] = m_latch[i];
                    m_cnt = NBUSY;
                end
                m_mask = 0;
            end
        end
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wbyte(input int d, input bit wpv);
        cyc(0, 0, 1, d, 0, 0, wpv);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;
        for (int i = 0; i < 16; i++) m_latch[i] = 0;
        m_mask = 0; m_addr = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, then a full sweep of the erased array
        req = "R1";
        idle_n(2);
        req = "R10";
        for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 0, 0, 1, 0, 0);

        // R2, R5, R6: single byte write, array unchanged until stop, busy window
        req = "R2";
        cyc(1, 'h23, 0, 0, 0, 0, 0);
        req = "R5";
        wbyte('hA5, 0);
        idle_n(2);
        cyc(1, 'h23, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        req = "R6";
        idle_n(NBUSY + 3);
        cyc(1, 'h23, 0, 0, 0, 0, 0);

        // R3, R4: 20 bytes from offset 12 wrap inside the page
        req = "R3";
        cyc(1, 'h1C, 0, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) wbyte(i * 7 + 3, 0);
        req = "R4";
        cyc(0, 0, 0, 0, 0, 1, 0);

        // R7: every request is ignored during the program cycle
        req = "R7";
        cyc(1, 'h99, 0, 0, 0, 0, 0);
        wbyte('h5A, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        idle_n(NBUSY);
        req = "R4";
        cyc(1, 'h10, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 1, 0, 0);

        // R5: two bytes only; neighbours in the page stay erased
        req = "R5";
        cyc(1, 'h66, 0, 0, 0, 0, 0);
        wbyte('h11, 0);
        wbyte('h22, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        idle_n(NBUSY + 1);
        cyc(1, 'h60, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 1, 0, 0);

        // R8: protected bytes and stop
        req = "R8";
        cyc(1, 'h40, 0, 0, 0, 0, 1);
        for (int i = 0; i < 3; i++) wbyte('h77, 1);
        cyc(0, 0, 0, 0, 0, 1, 1);
        idle_n(3);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0, 0);

        // R9: address-only transaction then stop
        req = "R9";
        cyc(1, 'h50, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        idle_n(3);

        // R10: read step from the top address wraps to zero
        req = "R10";
        cyc(1, DEPTH - 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        idle_n(2);

        done = 1;
        summary();
    end
endmodule